// File: doc/BRIEF.md
# Datapath ALU with Fixed Shifter

This block is the arithmetic stage of a microcoded datapath. Two 32-bit operand buses come in. Each operand passes through its own gate, and the left operand can then be complemented. One of four base functions combines the two operands, and the result goes through a fixed shifter onto the result bus. A control word drives the block once per datapath cycle. It can produce constants (0, 1, -1), increments, decrements, subtraction and negation by combining the gates, the inversion, the forced carry and the four functions.

The block is purely combinational. It holds no state, so it has no states or transitions to list. The negative and zero status bits are taken from the function result before the shifter, so the sequencer can branch on a value while the shifter rescales it. A control word that asks for both shifts at once is reported on a separate output and is then treated as no shift.

Top module: `dpalu_top`

## Requirements
- R1: `fn_sel` chooses the base function: 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives NOT B, and 2'b11 gives A + B, where A and B are the operands after gating and inversion.
- R2: When `gate_a` is 0 the left operand is zero. When `gate_b` is 0 the right operand is zero.
- R3: When `invert_a` is 1 the left operand is complemented after gating, so a gated-off left operand becomes all ones.
- R4: When `force_carry` is 1 and the sum function is selected, one is added to the sum. In the three logic functions `force_carry` has no effect. Gating B alone, selecting sum and forcing the carry with no shift gives B + 1.
- R5: When `shl8` and `sra1` are both 0, `c_out` equals the function result.
- R6: When only `shl8` is 1, `c_out` is the function result shifted left by 8, with its low 8 bits zero.
- R7: When only `sra1` is 1, `c_out` is the function result shifted right by 1 with the MSB copied, so -14 becomes -7.
- R8: `neg_flag` equals bit 31 of the function result before the shifter.
- R9: `zero_flag` is 1 exactly when the function result before the shifter is all zeros.
- R10: When `shl8` and `sra1` are both 1, `shift_illegal` is 1 and `c_out` equals the unshifted function result. Otherwise `shift_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Left operand bus |
| b_in | input | 32 | Right operand bus |
| fn_sel | input | 2 | Base function select |
| gate_a | input | 1 | Pass the left operand (0 forces it to zero) |
| gate_b | input | 1 | Pass the right operand (0 forces it to zero) |
| invert_a | input | 1 | Complement the left operand after gating |
| force_carry | input | 1 | Carry of 1 into the adder LSB |
| shl8 | input | 1 | Shift left by 8 with zero fill |
| sra1 | input | 1 | Arithmetic shift right by 1 |
| c_out | output | 32 | Result bus after the shifter |
| neg_flag | output | 1 | MSB of the unshifted result |
| zero_flag | output | 1 | Unshifted result is zero |
| shift_illegal | output | 1 | Both shift lines asserted |

## Verification
Whenever the inputs change, the embedded assertions check the following:
- the gates force disabled operands to zero;
- the sum path is consistent with its operands and carry;
- the shifter keeps its pass-through, zero-fill and sign-copy rules;
- the illegal-shift code falls back to pass-through;
- the two flags are never set together.

Some behaviours depend on the values as a whole rather than on one stage: the full function results, constants built from gating and inversion, the increment idiom, and the halving of -14. Only the bench's directed and random control words, compared against independently computed expected values, can show these.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_BAD   = 2'b11
    } shift_mode_e;
endpackage

// File: rtl/dpalu_gate.sv
module dpalu_gate #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b_raw,
    input  logic         gate_a,
    input  logic         gate_b,
    input  logic         invert_a,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);
    logic [W-1:0] a_gated;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign a_gated[i] = a_raw[i] & gate_a;
        assign op_a[i]    = a_gated[i] ^ invert_a;
        assign op_b[i]    = b_raw[i] & gate_b;
    end

    always_comb begin
        a_r2_gate_b_zero: assert (gate_b || op_b == '0);
        a_r3_inv_const: assert (gate_a || op_a == {W{invert_a}});
    end
endmodule

// File: rtl/dpalu_core.sv
module dpalu_core
    import dpalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    input  logic         carry,
    output logic [W-1:0] res
);
    logic [W-1:0] sum;
    assign sum = op_a + op_b + {{(W-1){1'b0}}, carry};

    always_comb begin
        unique case (fn)
            FN_AND:  res = op_a & op_b;
            FN_OR:   res = op_a | op_b;
            FN_NOTB: res = ~op_b;
            FN_SUM:  res = sum;
            default: res = '0;
        endcase
    end

    always_comb begin
        if (fn == FN_SUM) begin
            a_r4_sum_consistent: assert (res - op_b - op_a == {{(W-1){1'b0}}, carry});
        end
        if (fn == FN_NOTB) begin
            a_r1_notb_disjoint: assert ((res & op_b) == '0);
        end
    end
endmodule

// File: rtl/dpalu_shifter.sv
module dpalu_shifter
    import dpalu_pkg::*;
#(
    parameter int W      = 32,
    parameter int LSHIFT = 8
) (
    input  logic [W-1:0] din,
    input  logic         left_req,
    input  logic         right_req,
    output logic [W-1:0] dout,
    output logic         bad_code
);
    shift_mode_e mode;
    assign mode = shift_mode_e'({right_req, left_req});

    always_comb begin
        bad_code = 1'b0;
        unique case (mode)
            SH_PASS:  dout = din;
            SH_LEFT:  dout = {din[W-1-LSHIFT:0], {LSHIFT{1'b0}}};
            SH_RIGHT: dout = {din[W-1], din[W-1:1]};
            SH_BAD: begin
                dout     = din;
                bad_code = 1'b1;
            end
            default:  dout = din;
        endcase
    end

    always_comb begin
        if (!left_req && !right_req) a_r5_pass_through: assert (dout == din);
        if (left_req && !right_req) a_r6_zero_fill: assert (dout[LSHIFT-1:0] == '0);
        if (right_req && !left_req) a_r7_keep_msb: assert (dout[W-1] == din[W-1] && dout[W-2] == din[W-1]);
        if (left_req && right_req) a_r10_bad_is_pass: assert (bad_code && dout == din);
    end
endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    output logic         neg,
    output logic         zero
);
    assign neg  = res[W-1];
    assign zero = ~|res;

    always_comb begin
        a_r9_flags_exclusive: assert (!(neg && zero));
    end
endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
    import dpalu_pkg::*;
#(
    parameter int W      = 32,
    parameter int LSHIFT = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [1:0]   fn_sel,
    input  logic         gate_a,
    input  logic         gate_b,
    input  logic         invert_a,
    input  logic         force_carry,
    input  logic         shl8,
    input  logic         sra1,
    output logic [W-1:0] c_out,
    output logic         neg_flag,
    output logic         zero_flag,
    output logic         shift_illegal
);
    logic [W-1:0] op_a, op_b, alu_res;

    dpalu_gate #(.W(W)) u_gate (
        .a_raw(a_in), .b_raw(b_in), .gate_a(gate_a), .gate_b(gate_b),
        .invert_a(invert_a), .op_a(op_a), .op_b(op_b)
    );

    dpalu_core #(.W(W)) u_core (
        .op_a(op_a), .op_b(op_b), .fn(alu_fn_e'(fn_sel)),
        .carry(force_carry), .res(alu_res)
    );

    dpalu_shifter #(.W(W), .LSHIFT(LSHIFT)) u_shift (
        .din(alu_res), .left_req(shl8), .right_req(sra1),
        .dout(c_out), .bad_code(shift_illegal)
    );

    dpalu_flags #(.W(W)) u_flags (
        .res(alu_res), .neg(neg_flag), .zero(zero_flag)
    );

    always_comb begin
        if (!shl8 && !sra1) a_r8_neg_tracks_out: assert (neg_flag == c_out[W-1]);
        if (shift_illegal) a_r10_illegal_both: assert (shl8 && sra1);
    end
endmodule

// File: tb/dpalu_top_tb_top.sv
module dpalu_top_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] a_in, b_in, c_out;
    logic [1:0]  fn_sel;
    logic gate_a, gate_b, invert_a, force_carry, shl8, sra1;
    logic neg_flag, zero_flag, shift_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    dpalu_top dut_i (
        .a_in(a_in), .b_in(b_in), .fn_sel(fn_sel), .gate_a(gate_a), .gate_b(gate_b),
        .invert_a(invert_a), .force_carry(force_carry), .shl8(shl8), .sra1(sra1),
        .c_out(c_out), .neg_flag(neg_flag), .zero_flag(zero_flag),
        .shift_illegal(shift_illegal)
    );

    function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] fs, input logic ea, input logic eb,
                                            input logic ia, input logic ci);
        logic [31:0] x, y;
        x = ea ? a : 32'h0;
        if (ia) x = ~x;
        y = eb ? b : 32'h0;
        case (fs)
            2'b00:   return x & y;
            2'b01:   return x | y;
            2'b10:   return ~y;
            default: return x + y + (ci ? 32'd1 : 32'd0);
        endcase
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic l, input logic r);
        if (l && !r) return v << 8;
        if (r && !l) return $signed(v) >>> 1;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] fs,
                         input logic ea, input logic eb, input logic ia, input logic ci,
                         input logic l, input logic r);
        @(posedge clk);
        a_in = a; b_in = b; fn_sel = fs; gate_a = ea; gate_b = eb;
        invert_a = ia; force_carry = ci; shl8 = l; sra1 = r;
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] r;
        r = ref_alu(a_in, b_in, fn_sel, gate_a, gate_b, invert_a, force_carry);
        check({tag, " c_out"}, c_out, ref_shift(r, shl8, sra1));
        check("R8 neg", {31'h0, neg_flag}, {31'h0, r[31]});
        check("R9 zero", {31'h0, zero_flag}, {31'h0, r == 32'h0});
        check("R10 illegal", {31'h0, shift_illegal}, {31'h0, shl8 & sra1});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        apply(0, 0, 2'b00, 0, 0, 0, 0, 0, 0);
        check("R9 idle c_out", c_out, 32'h0);
        check("R9 idle zero", {31'h0, zero_flag}, 32'h1);

        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00, 1, 1, 0, 0, 0, 0);
        check("R1 and", c_out, 32'h00F0_1234);
        apply(32'hF0F0_1234, 32'h0FF0_0000, 2'b01, 1, 1, 0, 0, 0, 0);
        check("R1 or", c_out, 32'hFFF0_1234);
        apply(32'h1111_1111, 32'h0000_FFFF, 2'b10, 1, 1, 0, 0, 0, 0);
        check("R1 notb", c_out, 32'hFFFF_0000);
        apply(32'hDEAD_BEEF, 32'h1234_5678, 2'b11, 0, 1, 0, 0, 0, 0);
        check("R2 gate_a off", c_out, 32'h1234_5678);
        apply(32'hDEAD_BEEF, 32'h1234_5678, 2'b11, 1, 0, 0, 0, 0, 0);
        check("R2 gate_b off", c_out, 32'hDEAD_BEEF);
        apply(32'h1234_5678, 32'h0, 2'b11, 0, 0, 1, 0, 0, 0);
        check("R3 minus one", c_out, 32'hFFFF_FFFF);
        apply(32'd5, 32'd9, 2'b11, 1, 1, 1, 1, 0, 0);
        check("R3 subtract", c_out, 32'd4);
        apply(32'h0, 32'h0000_00FF, 2'b11, 0, 1, 0, 1, 0, 0);
        check("R4 increment", c_out, 32'h0000_0100);
        apply(32'hAAAA_0000, 32'h0000_5555, 2'b01, 1, 1, 0, 1, 0, 0);
        check("R4 carry ignored", c_out, 32'hAAAA_5555);
        apply(32'h0, 32'h8765_4321, 2'b11, 0, 1, 0, 0, 0, 0);
        check("R5 pass", c_out, 32'h8765_4321);
        apply(32'h0, 32'h8765_4321, 2'b11, 0, 1, 0, 0, 1, 0);
        check("R6 shl8", c_out, 32'h6543_2100);
        apply(32'h0, 32'hFFFF_FFF2, 2'b11, 0, 1, 0, 0, 0, 1);
        check("R7 minus14", c_out, 32'hFFFF_FFF9);
        check("R8 neg", {31'h0, neg_flag}, 32'h1);
        apply(32'h1, 32'h0, 2'b11, 1, 0, 0, 0, 0, 1);
        check("R9 zero after shift", {31'h0, zero_flag}, 32'h0);
        check("R7 one to zero", c_out, 32'h0);
        apply(32'h0, 32'h8000_00FF, 2'b11, 0, 1, 0, 0, 1, 0);
        check("R8 neg before shift", {31'h0, neg_flag}, 32'h1);
        apply(32'h0, 32'hC000_0003, 2'b11, 0, 1, 0, 0, 1, 1);
        check("R10 bad pass", c_out, 32'hC000_0003);
        check("R10 flag", {31'h0, shift_illegal}, 32'h1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb, ctl;
            ra = $urandom; rb = $urandom; ctl = $urandom;
            apply(ra, rb, ctl[1:0], ctl[2], ctl[3], ctl[4], ctl[5], ctl[6], ctl[7]);
            check_all("R1 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule